// File: doc/BRIEF.md
# Capture/Playback Sample Buffer Controller

This block holds a burst of streamed samples in an on-chip word array and then sends them on. A valid/ready source feeds it, and a valid/ready destination drains it. A synthesis parameter fixes its role.

As a capture path, it fills the array from the source until it has a programmed number of words, or until the array is full. It then drains exactly that many words to the destination. As a playback path, it loads the whole array and then plays the array out. A second parameter decides whether playback happens once or repeats from the first word without end.

A two-bit synchronization field decides what starts the transfer. In capture, this field gates filling. In playback, it gates the first output word. A small word-addressed register port carries the control, status and debug fields. An active-low run bit acts as a local reset of the transfer logic.

Top module: `sample_buf_ctl`

## Requirements
- R1: Address 0x0 reads 0x44414F46. Address 0x1 reads the configuration: bits [13:8] hold MEM_LOG2 (the array size in bytes, as a log2), bit 2 is 0 (no bypass), bit 1 is TX_PATH, and bit 0 is 0 (on-chip memory).
- R2: When sync code 0 (CTRL address 0x3, bits [5:4]) is set, the gated side starts without any further event.
- R3: Sync code 1 makes the gated side wait for a one-cycle high pulse on `ext_trig`.
- R4: Sync code 2 makes the gated side wait for a write of 1 to bit 0 of address 0x4.
- R5: Sync code 3 never starts the gated side, whatever `ext_trig` does and whatever is written to address 0x4.
- R6: In capture, the LENGTH register (address 0x2) gives the length in 64-byte units. For a 32-bit word this is 16 words per unit. A value of 0, or a length that does not fit in the array, captures the full array (64 words by default). `src_ready` is high only while filling.
- R7: Output words appear only once filling is complete. They come out in write order, starting from word 0. In capture and in one-shot playback, output stops after the stored count.
- R8: With TX_PATH=1 and CYCLIC=1, playback wraps to word 0 after the last word and continues.
- R9: In playback, raising `dst_ready` after the buffer has ended sets a sticky underflow flag (STATUS address 0x5, bit 0).
- R10: In capture, presenting `src_valid` after the buffer is complete sets a sticky overflow flag (STATUS bit 1).
- R11: A 64-bit count of accepted input words reads as a low word at address 0x7 and a high word at address 0x8.
- R12: Clearing the run bit (CTRL bit 0) returns both state machines to idle. It also clears the word count and both flags.
- R13: With AUTO_START=1, the run bit resets to 1, so the block runs with sync code 0 and no register writes. With AUTO_START=0, the run bit resets to 0.
- R14: Address 0x6 reads the write-side state in bits [4:0] and the read-side state in bits [11:8]. Each state is coded as 0 idle, 1 waiting, 2 active, 3 done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_valid | input | 1 | Source word valid |
| src_ready | output | 1 | Block accepts a source word |
| src_data | input | DATA_W | Source word |
| dst_valid | output | 1 | Output word valid |
| dst_ready | input | 1 | Destination accepts a word |
| dst_data | output | DATA_W | Output word |
| ext_trig | input | 1 | External start trigger |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
Several internal faults show up at the ports:
- A wrong start decision in the gating logic shows as `src_ready` or `dst_valid` rising one to two cycles after a trigger that should have been ignored. It can also show as these signals never rising at all.
- A wrong length latch or a wrong pointer shows as an extra or a missing handshake at the end of a burst, or as a data word that is out of order.
- A flag or counter that is not cleared shows in the status, count or debug words right after the run bit drops.

// File: rtl/bufctl_pkg.sv
package bufctl_pkg;

    typedef enum logic [4:0] {
        W_IDLE = 5'd0,
        W_WAIT = 5'd1,
        W_FILL = 5'd2,
        W_DONE = 5'd3
    } wr_state_e;

    typedef enum logic [3:0] {
        R_IDLE = 4'd0,
        R_WAIT = 4'd1,
        R_PLAY = 4'd2,
        R_DONE = 4'd3
    } rd_state_e;

    typedef enum logic [1:0] {
        SYNC_AUTO = 2'd0,
        SYNC_EXT  = 2'd1,
        SYNC_SOFT = 2'd2,
        SYNC_RSVD = 2'd3
    } sync_e;

    localparam logic [31:0] BLOCK_ID = 32'h4441_4F46;

    localparam logic [3:0] A_ID     = 4'h0;
    localparam logic [3:0] A_CONFIG = 4'h1;
    localparam logic [3:0] A_LENGTH = 4'h2;
    localparam logic [3:0] A_CTRL   = 4'h3;
    localparam logic [3:0] A_TRIG   = 4'h4;
    localparam logic [3:0] A_STATUS = 4'h5;
    localparam logic [3:0] A_FSM    = 4'h6;
    localparam logic [3:0] A_BEAT_L = 4'h7;
    localparam logic [3:0] A_BEAT_H = 4'h8;

endpackage

// File: rtl/bufctl_ram.sv
module bufctl_ram #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/bufctl_wr.sv
module bufctl_wr
    import bufctl_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter bit TX_PATH = 1'b0,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start_ok,
    input  logic [CNT_W-1:0] target,
    input  logic             src_valid,
    output logic             src_ready,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [CNT_W-1:0] len,
    output wr_state_e        state
);

    typedef struct packed {
        wr_state_e        state;
        logic [CNT_W-1:0] ptr;
        logic [CNT_W-1:0] len;
    } wr_t;

    wr_t q, d;

    always_comb begin
        d         = q;
        src_ready = (q.state == W_FILL);
        wr_en     = src_ready && src_valid;
        unique case (q.state)
            W_IDLE: if (run) d.state = W_WAIT;
            W_WAIT: if (TX_PATH || start_ok) begin
                d.state = W_FILL;
                d.ptr   = '0;
                d.len   = target;
            end
            W_FILL: if (wr_en) begin
                d.ptr = q.ptr + CNT_W'(1);
                if (q.ptr == q.len - CNT_W'(1)) d.state = W_DONE;
            end
            default: ;
        endcase
        if (!run) begin
            d.state = W_IDLE;
            d.ptr   = '0;
            d.len   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= W_IDLE;
            q.ptr   <= '0;
            q.len   <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_addr = q.ptr[PTR_W-1:0];
    assign len     = q.len;
    assign state   = q.state;

    AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == W_FILL) |-> (q.ptr < q.len && q.len != '0)); // R6

endmodule

// File: rtl/bufctl_rd.sv
module bufctl_rd
    import bufctl_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter bit TX_PATH = 1'b0,
    parameter bit CYCLIC  = 1'b0,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start_ok,
    input  logic             wr_done,
    input  logic [CNT_W-1:0] len,
    input  logic             dst_ready,
    output logic             dst_valid,
    output logic [PTR_W-1:0] rd_addr,
    output rd_state_e        state
);

    localparam bit WRAP = TX_PATH && CYCLIC;

    typedef struct packed {
        rd_state_e        state;
        logic [CNT_W-1:0] ptr;
    } rd_t;

    rd_t q, d;

    always_comb begin
        d         = q;
        dst_valid = (q.state == R_PLAY);
        unique case (q.state)
            R_IDLE: if (wr_done) d.state = R_WAIT;
            R_WAIT: if (!TX_PATH || start_ok) begin
                d.state = R_PLAY;
                d.ptr   = '0;
            end
            R_PLAY: if (dst_ready) begin
                if (q.ptr == len - CNT_W'(1)) begin
                    if (WRAP) d.ptr = '0;
                    else      d.state = R_DONE;
                end else begin
                    d.ptr = q.ptr + CNT_W'(1);
                end
            end
            default: ;
        endcase
        if (!run) begin
            d.state = R_IDLE;
            d.ptr   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= R_IDLE;
            q.ptr   <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_addr = q.ptr[PTR_W-1:0];
    assign state   = q.state;

    AST_PLAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == R_PLAY) |-> (q.ptr < len)); // R7

endmodule

// File: rtl/sample_buf_ctl.sv
module sample_buf_ctl
    import bufctl_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int MEM_LOG2   = 8,
    parameter bit TX_PATH    = 1'b0,
    parameter bit CYCLIC     = 1'b0,
    parameter bit AUTO_START = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    output logic              dst_valid,
    input  logic              dst_ready,
    output logic [DATA_W-1:0] dst_data,
    input  logic              ext_trig,
    input  logic [3:0]        reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    localparam int BYTES_W    = DATA_W / 8;
    localparam int DEPTH      = (1 << MEM_LOG2) / BYTES_W;
    localparam int PTR_W      = $clog2(DEPTH);
    localparam int CNT_W      = PTR_W + 1;
    localparam int UNIT_WORDS = 64 / BYTES_W;
    localparam int MAX_UNITS  = DEPTH / UNIT_WORDS;

    typedef struct packed {
        logic        run;
        sync_e       sync;
        logic [31:0] len;
        logic        sw_go;
        logic        ovf;
        logic        unf;
        logic [63:0] beats;
    } ctl_t;

    ctl_t q, d;

    wr_state_e        wr_state;
    rd_state_e        rd_state;
    logic             start_ok;
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] cap_len;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [PTR_W-1:0] rd_addr;

    always_comb begin
        unique case (q.sync)
            SYNC_AUTO: start_ok = 1'b1;
            SYNC_EXT:  start_ok = ext_trig;
            SYNC_SOFT: start_ok = q.sw_go;
            default:   start_ok = 1'b0;
        endcase
        if (TX_PATH || q.len == '0 || q.len >= 32'(MAX_UNITS))
            target = CNT_W'(DEPTH);
        else
            target = CNT_W'(q.len * 32'(UNIT_WORDS));
    end

    always_comb begin
        d       = q;
        d.sw_go = 1'b0;
        if (reg_we) begin
            unique case (reg_addr)
                A_LENGTH: d.len = reg_wdata;
                A_CTRL: begin
                    d.run  = reg_wdata[0];
                    d.sync = sync_e'(reg_wdata[5:4]);
                end
                A_TRIG:  d.sw_go = reg_wdata[0];
                default: ;
            endcase
        end
        if (wr_en) d.beats = q.beats + 64'd1;
        if (!TX_PATH && wr_state == W_DONE && src_valid) d.ovf = 1'b1;
        if (TX_PATH && rd_state == R_DONE && dst_ready)  d.unf = 1'b1;
        if (!q.run) begin
            d.beats = '0;
            d.ovf   = 1'b0;
            d.unf   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.run   <= AUTO_START;
            q.sync  <= SYNC_AUTO;
            q.len   <= '0;
            q.sw_go <= 1'b0;
            q.ovf   <= 1'b0;
            q.unf   <= 1'b0;
            q.beats <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_ID:     reg_rdata = BLOCK_ID;
            A_CONFIG: reg_rdata = {18'd0, 6'(MEM_LOG2), 5'd0, 1'b0, TX_PATH, 1'b0};
            A_LENGTH: reg_rdata = q.len;
            A_CTRL:   reg_rdata = {26'd0, q.sync, 3'd0, q.run};
            A_STATUS: reg_rdata = {30'd0, q.ovf, q.unf};
            A_FSM:    reg_rdata = {20'd0, rd_state, 3'd0, wr_state};
            A_BEAT_L: reg_rdata = q.beats[31:0];
            A_BEAT_H: reg_rdata = q.beats[63:32];
            default:  reg_rdata = 32'd0;
        endcase
    end

    bufctl_wr #(.DEPTH(DEPTH), .TX_PATH(TX_PATH)) u_wr (
        .clk(clk), .rst_n(rst_n), .run(q.run), .start_ok(start_ok),
        .target(target), .src_valid(src_valid), .src_ready(src_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .len(cap_len), .state(wr_state)
    );

    bufctl_rd #(.DEPTH(DEPTH), .TX_PATH(TX_PATH), .CYCLIC(CYCLIC)) u_rd (
        .clk(clk), .rst_n(rst_n), .run(q.run), .start_ok(start_ok),
        .wr_done(wr_state == W_DONE), .len(cap_len), .dst_ready(dst_ready),
        .dst_valid(dst_valid), .rd_addr(rd_addr), .state(rd_state)
    );

    bufctl_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(src_data),
        .raddr(rd_addr), .rdata(dst_data)
    );

    generate
        if (TX_PATH) begin : g_tx_chk
            AST_RSVD_NO_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
                (q.sync == SYNC_RSVD && rd_state == R_WAIT) |=> (rd_state != R_PLAY)); // R5
        end else begin : g_rx_chk
            AST_RSVD_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
                (q.sync == SYNC_RSVD && wr_state == W_WAIT) |=> (wr_state != W_FILL)); // R5
        end
    endgenerate

    AST_DRAIN_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid |-> (wr_state == W_DONE)); // R7

    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && q.ovf) |=> q.ovf); // R10

    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && q.unf) |=> q.unf); // R9

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        q.run |=> (q.beats == $past(q.beats) || q.beats == $past(q.beats) + 64'd1)); // R11

    AST_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !q.run |=> (wr_state == W_IDLE && rd_state == R_IDLE)); // R12

endmodule

// File: tb/sample_buf_ctl_test.sv
module sample_buf_ctl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sv [3];
    logic        sr [3];
    logic [31:0] sd [3];
    logic        dv [3];
    logic        dr [3];
    logic [31:0] dd [3];
    logic        we [3];
    logic [31:0] rdat [3];
    logic [3:0]  addr = '0;
    logic [31:0] wdat = '0;
    logic        ext = 1'b0;
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] v;

    always #4 clk = ~clk;

    // uut: capture path; uut_tc: cyclic playback with auto start; uut_tn: one-shot playback
    sample_buf_ctl #(.TX_PATH(1'b0), .CYCLIC(1'b0), .AUTO_START(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .src_valid(sv[0]), .src_ready(sr[0]), .src_data(sd[0]),
        .dst_valid(dv[0]), .dst_ready(dr[0]), .dst_data(dd[0]), .ext_trig(ext),
        .reg_addr(addr), .reg_we(we[0]), .reg_wdata(wdat), .reg_rdata(rdat[0]));
    sample_buf_ctl #(.TX_PATH(1'b1), .CYCLIC(1'b1), .AUTO_START(1'b1)) uut_tc (
        .clk(clk), .rst_n(rst_n), .src_valid(sv[1]), .src_ready(sr[1]), .src_data(sd[1]),
        .dst_valid(dv[1]), .dst_ready(dr[1]), .dst_data(dd[1]), .ext_trig(ext),
        .reg_addr(addr), .reg_we(we[1]), .reg_wdata(wdat), .reg_rdata(rdat[1]));
    sample_buf_ctl #(.TX_PATH(1'b1), .CYCLIC(1'b0), .AUTO_START(1'b0)) uut_tn (
        .clk(clk), .rst_n(rst_n), .src_valid(sv[2]), .src_ready(sr[2]), .src_data(sd[2]),
        .dst_valid(dv[2]), .dst_ready(dr[2]), .dst_data(dd[2]), .ext_trig(ext),
        .reg_addr(addr), .reg_we(we[2]), .reg_wdata(wdat), .reg_rdata(rdat[2]));

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(int u, logic [3:0] a, logic [31:0] val);
        @(negedge clk); addr = a; wdat = val; we[u] = 1'b1;
        @(negedge clk); we[u] = 1'b0;
    endtask

    task automatic rreg(int u, logic [3:0] a, output logic [31:0] val);
        @(negedge clk); addr = a; #1; val = rdat[u];
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(int u, int n, int base);
        int sent = 0;
        forever begin
            @(negedge clk);
            if (sent == n) begin sv[u] = 1'b0; break; end
            sv[u] = 1'b1;
            sd[u] = 32'(base + sent);
            if (sr[u]) sent++;
        end
    endtask

    task automatic pull(int u, int n, int base, int modv, string req);
        int got = 0;
        forever begin
            @(negedge clk);
            if (got == n) begin dr[u] = 1'b0; break; end
            dr[u] = 1'b1;
            if (dv[u]) begin
                chk(req, dd[u], 64'(base + (got % modv)));
                got++;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            sv[i] = 1'b0; sd[i] = '0; dr[i] = 1'b0; we[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        // R1 identification and configuration
        for (int u = 0; u < 3; u++) begin
            rreg(u, 4'h0, v); chk("R1 id", v, 32'h4441_4F46);
            rreg(u, 4'h1, v); chk("R1 config", v, (u == 0) ? 32'h800 : 32'h802);
        end
        // R13 auto start vs. held
        chk("R13 capture held", sr[0], 0);
        chk("R13 one-shot held", sr[2], 0);
        chk("R13 auto running", sr[1], 1);
        rreg(0, 4'h6, v); chk("R14 idle states", v, 0);
        rreg(0, 4'h7, v); chk("R11 beats reset", v, 0);

        // R2/R6 auto start, one 64-byte unit = 16 words
        wreg(0, 4'h2, 1);
        wreg(0, 4'h3, 32'h01);
        push(0, 16, 32'h100);
        idle(2);
        chk("R6 ready low after 16", sr[0], 0);
        rreg(0, 4'h7, v); chk("R11 beats 16", v, 16);
        rreg(0, 4'h8, v); chk("R11 beats high", v, 0);
        rreg(0, 4'h5, v); chk("R10 no overflow yet", v, 0);
        @(negedge clk); sv[0] = 1'b1;
        @(negedge clk); sv[0] = 1'b0;
        idle(3);
        rreg(0, 4'h5, v); chk("R10 overflow set", v, 2);
        rreg(0, 4'h5, v); chk("R10 overflow sticky", v, 2);
        pull(0, 16, 32'h100, 1 << 30, "R7 capture data");
        idle(2);
        chk("R7 stops after 16", dv[0], 0);
        rreg(0, 4'h6, v); chk("R14 done states", v, 32'h303);

        // R12 run bit clear
        wreg(0, 4'h3, 32'h00);
        idle(1);
        rreg(0, 4'h6, v); chk("R12 states idle", v, 0);
        rreg(0, 4'h7, v); chk("R12 beats cleared", v, 0);
        rreg(0, 4'h5, v); chk("R12 flags cleared", v, 0);

        // R3 external trigger, length 0 = full array
        wreg(0, 4'h2, 0);
        wreg(0, 4'h3, 32'h11);
        idle(8);
        chk("R3 waits for trigger", sr[0], 0);
        @(negedge clk); ext = 1'b1;
        @(negedge clk); ext = 1'b0;
        chk("R3 started", sr[0], 1);
        push(0, 64, 32'h200);
        idle(2);
        chk("R6 full array", sr[0], 0);
        rreg(0, 4'h7, v); chk("R11 beats 64", v, 64);
        pull(0, 64, 32'h200, 1 << 30, "R7 full data");
        idle(2);
        chk("R7 stops after 64", dv[0], 0);

        // R4 software trigger, two units = 32 words
        wreg(0, 4'h3, 32'h00);
        wreg(0, 4'h2, 2);
        wreg(0, 4'h3, 32'h21);
        ext = 1'b1; idle(6); ext = 1'b0;
        chk("R4 ignores ext pin", sr[0], 0);
        wreg(0, 4'h4, 1);
        @(negedge clk);
        chk("R4 started", sr[0], 1);
        push(0, 32, 32'h300);
        idle(2);
        chk("R6 two units", sr[0], 0);
        pull(0, 32, 32'h300, 1 << 30, "R7 two-unit data");
        idle(2);
        chk("R7 stops after 32", dv[0], 0);

        // R5 reserved code never starts
        wreg(0, 4'h3, 32'h00);
        wreg(0, 4'h2, 9);
        wreg(0, 4'h3, 32'h31);
        @(negedge clk); ext = 1'b1;
        @(negedge clk); ext = 1'b0;
        wreg(0, 4'h4, 1);
        idle(6);
        chk("R5 no start", sr[0], 0);
        rreg(0, 4'h6, v); chk("R5 R14 write waiting", v, 32'h001);

        // R6 oversize length capped at array size
        wreg(0, 4'h3, 32'h00);
        wreg(0, 4'h3, 32'h01);
        push(0, 64, 32'h400);
        idle(2);
        chk("R6 capped", sr[0], 0);
        rreg(0, 4'h7, v); chk("R11 capped beats", v, 64);
        pull(0, 64, 32'h400, 1 << 30, "R7 capped data");

        // R8 cyclic playback after auto bring-up
        push(1, 64, 32'h1000);
        pull(1, 133, 32'h1000, 64, "R8 cyclic data");
        rreg(1, 4'h6, v); chk("R8 R14 still playing", v, 32'h203);
        rreg(1, 4'h5, v); chk("R8 no underflow", v, 0);

        // R9 one-shot playback gated by software trigger
        wreg(2, 4'h3, 32'h21);
        push(2, 64, 32'h2000);
        idle(5);
        chk("R9 R4 playback waits", dv[2], 0);
        rreg(2, 4'h6, v); chk("R14 read waiting", v, 32'h103);
        wreg(2, 4'h4, 1);
        pull(2, 64, 32'h2000, 1 << 30, "R7 one-shot data");
        idle(1);
        chk("R7 one-shot ends", dv[2], 0);
        rreg(2, 4'h5, v); chk("R9 no underflow yet", v, 0);
        @(negedge clk); dr[2] = 1'b1;
        @(negedge clk); dr[2] = 1'b0;
        rreg(2, 4'h5, v); chk("R9 underflow set", v, 1);
        idle(4);
        rreg(2, 4'h5, v); chk("R9 underflow sticky", v, 1);
        wreg(2, 4'h3, 32'h00);
        idle(1);
        rreg(2, 4'h5, v); chk("R12 underflow cleared", v, 0);
        rreg(2, 4'h7, v); chk("R12 tx beats cleared", v, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule